// File: doc/BRIEF.md
# Video Control Register Slave on a Two-Wire Serial Bus

This block is the serial-bus front end of a video processing device. It watches the bus clock and data lines, which are sampled against a fast system clock, and recognises START and STOP. It answers one 7-bit address, and a strap input picks between two possible values of that address. Once it has been addressed for a write, the first byte it receives selects a control register. Every byte after that is stored in the selected register, and the register pointer then moves on by one. This lets a host load several neighbouring registers in a single transfer.

A read takes no register pointer. It always starts from the first byte of a fixed read-only stream. That stream holds a status byte, then two converter result bytes, then zeros. The status byte reports a latched power-loss flag and a small identification code. The power-loss flag is set by reset and by a pulse on the power-fail input. It is cleared once the host has read the status byte and acknowledged it. A strobe output pulses when that clearing read happens.

Bit 0 of control register 0 is the bus-control bit. While it is 0, the feature circuits outside this block follow their pins. Setting it to 1 hands them over to the control registers. The block answers its address whatever the state of this bit.

Top module: `vid_i2c_regbank`

## Requirements
- R1: The 7-bit address is {S,1,S,0,0,0,0}, where S is `adr_strap_i`. With S=0 the write byte is 0x40 and the read byte is 0x41. With S=1 they are 0xE0 and 0xE1. The slave acknowledges its own address (it pulls SDA low in the ninth clock) and does not acknowledge any other address.
- R2: In a write, the first data byte is taken as the register pointer. Each later data byte is stored in the register the pointer selects, and the pointer then increments. Control register k is seen at `ctrl_o[8k+7:8k]`.
- R3: A data byte whose pointer is NREG or above is still acknowledged but changes no register.
- R4: A read always begins at stream position 0. Each byte the host acknowledges advances the position by one. Position 0 is the status byte, position 1 is converter A and position 2 is converter B. Every later position reads as 0x00.
- R5: The status byte is {PDD, 0000, ID[2:0]}. Each converter byte is {valid, 0, value[5:0]}. All three are captured when the byte starts to be shifted out.
- R6: PDD is 1 after reset and is set by any cycle with `pwr_fail_i` high. It is cleared when the host acknowledges the status byte; a NACK on that byte leaves it set. A power-fail in the same cycle as the clearing acknowledge keeps PDD at 1.
- R7: `rd_strobe_o` is a one-cycle pulse for each acknowledged status byte.
- R8: `bus_ctrl_o` equals bit 0 of control register 0. It is 0 after reset, and the address is still acknowledged while it is 0.
- R9: After the host NACKs a read byte, the slave leaves SDA released until the next START.
- R10: A repeated START restarts decoding, so the next byte is treated as an address byte.
- R11: The slave only begins pulling SDA low while the synchronised SCL is low.
- R12: After reset every control register is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low_o | output | 1 | 1 pulls the data line low (open-drain) |
| adr_strap_i | input | 1 | Address select strap |
| pwr_fail_i | input | 1 | Supply interruption flag, sets PDD |
| chip_id_i | input | IDW | Identification code placed in the status byte |
| adc_a_i | input | ADCW | Converter A result |
| adc_a_valid_i | input | 1 | Converter A data valid |
| adc_b_i | input | ADCW | Converter B result |
| adc_b_valid_i | input | 1 | Converter B data valid |
| ctrl_o | output | NREG*8 | Control register contents, register k at bits 8k+7:8k |
| bus_ctrl_o | output | 1 | Feature control handed to bus registers |
| rd_strobe_o | output | 1 | Pulse when the status byte is acknowledged |

## Verification
The hardest case is a power-fail pulse that lands in the exact system-clock cycle in which the host's acknowledge of the status byte takes effect. The bus lines pass through a two-stage synchroniser and an edge detector before they reach the control logic. The bench therefore raises SCL for the acknowledge bit and counts two clock edges. It then holds `pwr_fail_i` high for the single cycle that contains the third edge. It checks that the strobe still fired and that a later status read still shows PDD set.

// File: rtl/vid_i2c_pkg.sv
package vid_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } bus_state_t;

  // strap drives two address bits
  function automatic logic [6:0] own_addr(input logic strap);
    return {strap, 1'b1, strap, 4'b0000};
  endfunction

endpackage

// File: rtl/vid_i2c_linesync.sv
module vid_i2c_linesync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [1:0] scl_sr, sda_sr;
  logic       scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= 2'b11;
      sda_sr <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[0], scl_i};
      sda_sr <= {sda_sr[0], sda_i};
      scl_p  <= scl_sr[1];
      sda_p  <= sda_sr[1];
    end
  end

  assign scl_s     = scl_sr[1];
  assign sda_s     = sda_sr[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/vid_i2c_status.sv
module vid_i2c_status #(
  parameter int ADCW = 6,
  parameter int IDW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_fail_i,
  input  logic            clr_req,
  input  logic [IDW-1:0]  chip_id_i,
  input  logic [ADCW-1:0] adc_a_i,
  input  logic            adc_a_valid_i,
  input  logic [ADCW-1:0] adc_b_i,
  input  logic            adc_b_valid_i,
  input  logic [1:0]      sel,
  output logic            pdd_q,
  output logic            strobe_q,
  output logic [7:0]      rd_byte
);
  localparam int IDPAD  = 7 - IDW;
  localparam int ADCPAD = 7 - ADCW;

  always_ff @(posedge clk) begin
    if (rst) begin
      pdd_q    <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= clr_req;
      if (pwr_fail_i)   pdd_q <= 1'b1;
      else if (clr_req) pdd_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      2'd0:    rd_byte = {pdd_q, {IDPAD{1'b0}}, chip_id_i};
      2'd1:    rd_byte = {adc_a_valid_i, {ADCPAD{1'b0}}, adc_a_i};
      2'd2:    rd_byte = {adc_b_valid_i, {ADCPAD{1'b0}}, adc_b_i};
      default: rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/vid_i2c_ctlregs.sv
module vid_i2c_ctlregs #(
  parameter int NREG = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_req,
  input  logic [7:0]      wr_ptr,
  input  logic [7:0]      wr_data,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
    end else if (wr_req) begin
      for (int i = 0; i < NREG; i++)
        if (wr_ptr == 8'(i)) regs[i] <= wr_data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_flat
      assign regs_flat[g*8 +: 8] = regs[g];
    end
  endgenerate
endmodule

// File: rtl/vid_i2c_regbank.sv
module vid_i2c_regbank
  import vid_i2c_pkg::*;
#(
  parameter int NREG = 4,
  parameter int ADCW = 6,
  parameter int IDW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low_o,
  input  logic              adr_strap_i,
  input  logic              pwr_fail_i,
  input  logic [IDW-1:0]    chip_id_i,
  input  logic [ADCW-1:0]   adc_a_i,
  input  logic              adc_a_valid_i,
  input  logic [ADCW-1:0]   adc_b_i,
  input  logic              adc_b_valid_i,
  output logic [NREG*8-1:0] ctrl_o,
  output logic              bus_ctrl_o,
  output logic              rd_strobe_o
);
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  bus_state_t st;
  logic [3:0] bitcnt;
  logic [7:0] sh, tx, ptr;
  logic       rw, first, macked, drv;
  logic [1:0] rd_idx, rd_sel;
  logic [7:0] rd_byte;
  logic       pdd_q, wr_req, clr_req;

  vid_i2c_linesync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  assign wr_req  = (st == ST_WR) && scl_fall && (bitcnt == 4'd8) && !first && (ptr < NREG_B)
                   && !bus_start && !bus_stop;
  assign clr_req = (st == ST_RACK) && scl_rise && !sda_s && (rd_idx == 2'd0)
                   && !bus_start && !bus_stop;
  assign rd_sel  = (st == ST_AACK) ? 2'd0 : rd_idx;

  vid_i2c_status #(.ADCW(ADCW), .IDW(IDW)) u_stat (
    .clk(clk), .rst(rst), .pwr_fail_i(pwr_fail_i), .clr_req(clr_req),
    .chip_id_i(chip_id_i), .adc_a_i(adc_a_i), .adc_a_valid_i(adc_a_valid_i),
    .adc_b_i(adc_b_i), .adc_b_valid_i(adc_b_valid_i), .sel(rd_sel),
    .pdd_q(pdd_q), .strobe_q(rd_strobe_o), .rd_byte(rd_byte)
  );

  vid_i2c_ctlregs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_ptr(ptr), .wr_data(sh),
    .regs_flat(ctrl_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      bitcnt <= 4'd0;
      sh     <= 8'h00;
      tx     <= 8'h00;
      ptr    <= 8'h00;
      rw     <= 1'b0;
      first  <= 1'b0;
      macked <= 1'b0;
      drv    <= 1'b0;
      rd_idx <= 2'd0;
    end else if (bus_start) begin
      st     <= ST_ADDR;
      bitcnt <= 4'd0;
      drv    <= 1'b0;
    end else if (bus_stop) begin
      st  <= ST_IDLE;
      drv <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (st == ST_ADDR) begin
              if (sh[7:1] == own_addr(adr_strap_i)) begin
                st  <= ST_AACK;
                drv <= 1'b1;
                rw  <= sh[0];
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              st  <= ST_WACK;
              drv <= 1'b1;
              if (first) begin
                ptr   <= sh;
                first <= 1'b0;
              end else begin
                ptr <= ptr + 8'd1;
              end
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          if (rw) begin
            st     <= ST_RD;
            rd_idx <= 2'd0;
            tx     <= {rd_byte[6:0], 1'b0};
            drv    <= ~rd_byte[7];
            bitcnt <= 4'd1;
          end else begin
            st     <= ST_WR;
            first  <= 1'b1;
            drv    <= 1'b0;
            bitcnt <= 4'd0;
          end
        end
        ST_WACK: if (scl_fall) begin
          st     <= ST_WR;
          drv    <= 1'b0;
          bitcnt <= 4'd0;
        end
        ST_RD: if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            st  <= ST_RACK;
            drv <= 1'b0;
          end else begin
            drv    <= ~tx[7];
            tx     <= {tx[6:0], 1'b0};
            bitcnt <= bitcnt + 4'd1;
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            macked <= ~sda_s;
            if (!sda_s && rd_idx != 2'd3) rd_idx <= rd_idx + 2'd1;
          end else if (scl_fall) begin
            if (macked) begin
              st     <= ST_RD;
              tx     <= {rd_byte[6:0], 1'b0};
              drv    <= ~rd_byte[7];
              bitcnt <= 4'd1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_drive_low_o = drv;
  assign bus_ctrl_o      = ctrl_o[0];
endmodule

// File: rtl/vid_i2c_regbank_chk.sv
module vid_i2c_regbank_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         scl_s,
  input logic         sda_drive_low_o,
  input logic         pwr_fail_i,
  input logic         pdd_q,
  input logic         rd_strobe_o,
  input logic         wr_req,
  input logic [W-1:0] ctrl_o
);
  // R11
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low_o) |-> !scl_s);

  // R6
  pdd_set_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_fail_i |=> pdd_q);

  // R6
  pdd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe_o && !$past(pwr_fail_i) |-> !pdd_q);

  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe_o |=> !rd_strobe_o);

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> $stable(ctrl_o));

  // R12
  reset_release_chk: assert property (@(posedge clk)
    rst |=> !sda_drive_low_o && ctrl_o == '0);
endmodule

bind vid_i2c_regbank vid_i2c_regbank_chk #(.W(NREG*8)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_drive_low_o(sda_drive_low_o),
  .pwr_fail_i(pwr_fail_i), .pdd_q(pdd_q), .rd_strobe_o(rd_strobe_o),
  .wr_req(wr_req), .ctrl_o(ctrl_o)
);

// File: tb/vid_i2c_regbank_tb.sv
module vid_i2c_regbank_tb;
  localparam int NREG = 4;
  localparam int Q    = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1, sda_line;
  logic drv, strap = 1'b0, pwr_fail = 1'b0;
  logic [2:0] id = 3'b101;
  logic [5:0] adc_a = 6'h2A, adc_b = 6'h15;
  logic va = 1'b1, vb = 1'b0;
  logic [NREG*8-1:0] ctrl;
  logic bus_ctrl, strobe;

  int checks = 0, bad = 0, strobes = 0;
  bit cmp_en = 1'b0;
  bit pdd_m = 1'b1;
  logic [7:0] ctrl_m [NREG];

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~drv;

  vid_i2c_regbank #(.NREG(NREG)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_drive_low_o(drv),
    .adr_strap_i(strap), .pwr_fail_i(pwr_fail), .chip_id_i(id),
    .adc_a_i(adc_a), .adc_a_valid_i(va), .adc_b_i(adc_b), .adc_b_valid_i(vb),
    .ctrl_o(ctrl), .bus_ctrl_o(bus_ctrl), .rd_strobe_o(strobe)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  always @(posedge clk) if (!rst && strobe) strobes++;

  // per-clock comparison against the reference model while the bus is idle
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      checks++;
      for (int k = 0; k < NREG; k++)
        if (ctrl[k*8 +: 8] !== ctrl_m[k]) begin
          bad++;
          $display("FAIL R2 reg%0d actual=%0h expected=%0h", k, ctrl[k*8 +: 8], ctrl_m[k]);
        end
      if (bus_ctrl !== ctrl_m[0][0] || drv !== 1'b0) begin
        bad++;
        $display("FAIL R8/R12 bus_ctrl,drv actual=%0b%0b expected=%0b0", bus_ctrl, drv, ctrl_m[0][0]);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    cmp_en = 1'b0;
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
    cmp_en = 1'b1;
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    ack = !sda_line;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic rbyte(output logic [7:0] b, input bit mack, input bit pf);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0; wq(Q);
    end
    sda_m = !mack; wq(Q); scl = 1'b1;
    if (pf) begin
      wq(2); pwr_fail = 1'b1; wq(1); pwr_fail = 1'b0; wq(2*Q-3);
    end else begin
      wq(2*Q);
    end
    scl = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic model_write(int p, logic [7:0] d);
    if (p < NREG) ctrl_m[p] = d;
  endtask

  function automatic logic [7:0] status_exp();
    return {pdd_m, 4'b0000, id};
  endfunction

  task automatic pf_pulse();
    wq(2); pwr_fail = 1'b1; wq(1); pwr_fail = 1'b0; wq(2);
    pdd_m = 1'b1;
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    for (int k = 0; k < NREG; k++) ctrl_m[k] = 8'h00;
    wq(5); rst = 1'b0; wq(3);
    chk("R12 ctrl after reset", int'(ctrl), 0);
    chk("R12 drive after reset", int'(drv), 0);
    chk("R8 bus_ctrl after reset", int'(bus_ctrl), 0);
    cmp_en = 1'b1;

    // full read stream, strap low, STB still 0
    i2c_start(); wbyte(8'h41, ack);
    chk("R1/R8 read address ack", int'(ack), 1);
    rbyte(b, 1'b1, 1'b0); chk("R5 status byte", int'(b), int'(status_exp()));
    pdd_m = 1'b0;
    rbyte(b, 1'b1, 1'b0); chk("R5 adc A valid", int'(b), 8'hAA);
    rbyte(b, 1'b1, 1'b0); chk("R5 adc B invalid", int'(b), 8'h15);
    rbyte(b, 1'b0, 1'b0); chk("R4 beyond stream", int'(b), 8'h00);
    rbyte(b, 1'b0, 1'b0); chk("R9 released after NACK", int'(b), 8'hFF);
    i2c_stop();
    chk("R7 strobe count", strobes, 1);

    // PDD after power fail; NACK keeps it
    pf_pulse();
    i2c_start(); wbyte(8'h41, ack); rbyte(b, 1'b0, 1'b0); i2c_stop();
    chk("R6 pdd set by power fail", int'(b), int'(status_exp()));
    i2c_start(); wbyte(8'h41, ack); rbyte(b, 1'b0, 1'b0); i2c_stop();
    chk("R6 NACK keeps pdd", int'(b), 8'h85);
    chk("R7 no strobe on NACK", strobes, 1);

    // sequential writes
    i2c_start(); wbyte(8'h40, ack); chk("R1 write address ack", int'(ack), 1);
    wbyte(8'h01, ack); wbyte(8'h11, ack); wbyte(8'h22, ack);
    chk("R2 data ack", int'(ack), 1);
    i2c_stop();
    model_write(1, 8'h11); model_write(2, 8'h22);
    chk("R2 reg1", int'(ctrl[15:8]), 8'h11);
    chk("R2 reg2", int'(ctrl[23:16]), 8'h22);

    i2c_start(); wbyte(8'h40, ack); wbyte(8'h00, ack); wbyte(8'h01, ack); i2c_stop();
    model_write(0, 8'h01);
    chk("R8 bus control set", int'(bus_ctrl), 1);

    i2c_start(); wbyte(8'h40, ack); wbyte(8'h03, ack);
    wbyte(8'h33, ack); wbyte(8'h44, ack);
    chk("R3 out-of-range ack", int'(ack), 1);
    wbyte(8'h55, ack); i2c_stop();
    model_write(3, 8'h33);
    chk("R3 regs intact", int'(ctrl), int'({8'h33, 8'h22, 8'h11, 8'h01}));

    // foreign addresses
    i2c_start(); wbyte(8'hE0, ack); chk("R1 foreign E0 nack", int'(ack), 0);
    wbyte(8'h00, ack); wbyte(8'h00, ack); i2c_stop();
    i2c_start(); wbyte(8'h42, ack); chk("R1 foreign 42 nack", int'(ack), 0); i2c_stop();
    chk("R1 regs untouched", int'(ctrl[7:0]), 8'h01);

    // repeated START: write, then read restarting at position 0
    adc_a = 6'h3F; va = 1'b0;
    i2c_start(); wbyte(8'h40, ack); wbyte(8'h02, ack); wbyte(8'h77, ack);
    model_write(2, 8'h77);
    i2c_start(); wbyte(8'h41, ack); chk("R10 address after repeated start", int'(ack), 1);
    rbyte(b, 1'b1, 1'b0); chk("R4 read starts at status", int'(b), int'(status_exp()));
    pdd_m = 1'b0;
    rbyte(b, 1'b0, 1'b0); chk("R5 adc A snapshot", int'(b), 8'h3F);
    i2c_stop();
    chk("R10 reg2 written", int'(ctrl[23:16]), 8'h77);
    chk("R7 strobe count 2", strobes, 2);

    // power fail in the clearing cycle
    pf_pulse();
    i2c_start(); wbyte(8'h41, ack);
    rbyte(b, 1'b1, 1'b1); chk("R6 status before race", int'(b), 8'h85);
    rbyte(b, 1'b0, 1'b0); i2c_stop();
    chk("R7 strobe in race", strobes, 3);
    i2c_start(); wbyte(8'h41, ack); rbyte(b, 1'b0, 1'b0); i2c_stop();
    chk("R6 power fail wins", int'(b), 8'h85);

    // strap high
    strap = 1'b1; wq(4);
    i2c_start(); wbyte(8'h40, ack); chk("R1 strap high rejects 40", int'(ack), 0); i2c_stop();
    i2c_start(); wbyte(8'hE0, ack); chk("R1 strap high accepts E0", int'(ack), 1);
    wbyte(8'h00, ack); wbyte(8'h00, ack); i2c_stop();
    model_write(0, 8'h00);
    chk("R8 bus control cleared", int'(bus_ctrl), 0);
    i2c_start(); wbyte(8'hE1, ack); chk("R1 strap high read ack", int'(ack), 1);
    rbyte(b, 1'b0, 1'b0); i2c_stop();
    chk("R5 status strap high", int'(b), 8'h85);

    summary();
    $finish;
  end
endmodule